// File: doc/BRIEF.md
# Frame Clock Ratio Detector and Power-Up Sequencer

This block runs in the master-clock domain and keeps a converter datapath in power-down until the frame clock is present and the master-clock to frame-clock ratio is known. The frame clock is synchronized into the master-clock domain. Each rising edge of the synchronized frame clock closes one counting window and opens the next. The block reports a ratio once two back-to-back windows agree.

While the block is running, it compares every later window with the stored ratio. If a window gives a different count, the block drops back to power-down and starts measuring again from that same edge. A timeout counter detects a missing frame clock: if no rising edge arrives within `TIMEOUT` master-clock cycles, the block returns to power-down. The analog power control is modelled as the single `poweredUp` flag. The datapath reset is its inverse.

Top module: `pwrup_ratio_seq`

## Requirements
- R1: After reset, `poweredUp` is 0, `dpReset` is 1 and `ratio` is 0.
- R2: With no rising edge on `lrck` (held low or held high), `poweredUp` stays 0 for any length of time.
- R3: The measured ratio is the number of `mclk` cycles between two consecutive rising edges of `lrck`, for any value from 2 to `TIMEOUT`. While `poweredUp` is 1, `ratio` shows the stored value. While it is 0, `ratio` reads 0.
- R4: `poweredUp` becomes 1 only when two consecutive periods give equal counts. This happens at the third rising `mclk` edge after the `lrck` rising edge that closes the second equal period; two `mclk` edges of that delay are synchronizer stages.
- R5: If no `lrck` rising edge arrives for more than `TIMEOUT` cycles (default 4096), the block returns to power-down. `poweredUp` falls at the `TIMEOUT`+3rd `mclk` edge after the last `lrck` rise. A period of exactly `TIMEOUT` cycles is accepted, and a period of `TIMEOUT`+1 never powers up.
- R6: While powered up, a period whose count differs from the stored ratio clears `poweredUp` at the third `mclk` edge after the `lrck` rise that closes it. That edge starts a new measurement, so two further equal periods power the block up again with the new ratio.
- R7: `dpReset` is always the inverse of `poweredUp`.
- R8: During confirmation, a count that differs from the first one replaces it as the candidate. Power-up then needs the next period to match the new candidate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| lrck | input | 1 | Frame clock, asynchronous to the block until synchronized |
| ratio | output | CNT_W | Measured mclk cycles per lrck period, 0 while powered down |
| dpReset | output | 1 | Datapath reset, high while powered down |
| poweredUp | output | 1 | Power-up flag, high while running |

## Verification
A synchronized `lrck` rise and the timeout strobe can occur in the same cycle. The sweep reaches this case when the period equals `TIMEOUT` exactly. In that cycle the edge must win and the block must power up with ratio `TIMEOUT`. A period one cycle longer must never power up. A second collision is a rise that also carries a count mismatch while the block runs. A frame-clock step from 20 to 24 cycles provokes it, and the bench checks the cycle of the drop and the cycle of the re-lock.

// File: rtl/ratio_seq_pkg.sv
package ratio_seq_pkg;

  typedef enum logic [1:0] {
    ST_DOWN  = 2'd0,
    ST_FIRST = 2'd1,
    ST_CONF  = 2'd2,
    ST_RUN   = 2'd3
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic load;
  } ctlCmd_t;

  // datapath -> control
  typedef struct packed {
    logic rise;
    logic timeout;
    logic match;
  } dpFlag_t;

endpackage

// File: rtl/ratio_seq_dp.sv
module ratio_seq_dp
  import ratio_seq_pkg::*;
#(
  parameter int TIMEOUT     = 4096,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(TIMEOUT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lrck,
  input  ctlCmd_t          cmd,
  output dpFlag_t          flags,
  output logic [CNT_W-1:0] ratioReg
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lrckD;
  logic [CNT_W-1:0]       cnt;
  logic [CNT_W-1:0]       measured;
  logic                   riseW;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      lrckD <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], lrck};
      lrckD <= syncQ[SYNC_STAGES-1];
    end
  end

  assign riseW    = syncQ[SYNC_STAGES-1] & ~lrckD;
  assign measured = cnt + CNT_W'(1);

  // window counter: cleared by each edge, saturating at the timeout limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (riseW)       cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         ratioReg <= '0;
    else if (cmd.load) ratioReg <= measured;
  end

  always_comb begin
    flags.rise    = riseW;
    flags.timeout = (cnt == LAST);
    flags.match   = (measured == ratioReg);
  end

  // R5: the window counter never passes the timeout limit
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST);

  // R3: the stored ratio changes only when the control asks for a load
  p_ratio_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.load |=> $stable(ratioReg));

endmodule

// File: rtl/ratio_seq_ctl.sv
module ratio_seq_ctl
  import ratio_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpFlag_t flags,
  output ctlCmd_t cmd,
  output logic    upQ
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    cmd.load  = 1'b0;
    unique case (state)
      ST_DOWN: begin
        if (flags.rise) stateNext = ST_FIRST;
      end
      ST_FIRST: begin
        if (flags.rise) begin
          cmd.load  = 1'b1;
          stateNext = ST_CONF;
        end else if (flags.timeout) begin
          stateNext = ST_DOWN;
        end
      end
      ST_CONF: begin
        if (flags.rise) begin
          if (flags.match) stateNext = ST_RUN;
          else             cmd.load  = 1'b1;
        end else if (flags.timeout) begin
          stateNext = ST_DOWN;
        end
      end
      ST_RUN: begin
        if (flags.rise) begin
          if (!flags.match) stateNext = ST_FIRST;
        end else if (flags.timeout) begin
          stateNext = ST_DOWN;
        end
      end
      default: stateNext = ST_DOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_DOWN;
    else       state <= stateNext;
  end

  assign upQ = (state == ST_RUN);

  // R4: power-up follows an edge whose count matched the stored candidate
  p_up_needs_match_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(upQ) |-> $past(flags.rise && flags.match));

  // R5: a timeout without an edge ends the running state
  p_timeout_down_r5: assert property (@(posedge clk) disable iff (!rstN)
    (upQ && flags.timeout && !flags.rise) |=> !upQ);

  // R6: a mismatched period ends the running state
  p_mismatch_down_r6: assert property (@(posedge clk) disable iff (!rstN)
    (upQ && flags.rise && !flags.match) |=> !upQ);

  // R8: the candidate is never reloaded while running
  p_no_load_running_r8: assert property (@(posedge clk) disable iff (!rstN)
    upQ |-> !cmd.load);

endmodule

// File: rtl/pwrup_ratio_seq.sv
module pwrup_ratio_seq
  import ratio_seq_pkg::*;
#(
  parameter int TIMEOUT     = 4096,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(TIMEOUT + 1)
) (
  input  logic             mclk,
  input  logic             rstN,
  input  logic             lrck,
  output logic [CNT_W-1:0] ratio,
  output logic             dpReset,
  output logic             poweredUp
);

  ctlCmd_t          cmd;
  dpFlag_t          flags;
  logic [CNT_W-1:0] ratioReg;
  logic             upQ;

  ratio_seq_dp #(
    .TIMEOUT(TIMEOUT),
    .SYNC_STAGES(SYNC_STAGES),
    .CNT_W(CNT_W)
  ) u_dp (
    .clk(mclk),
    .rstN(rstN),
    .lrck(lrck),
    .cmd(cmd),
    .flags(flags),
    .ratioReg(ratioReg)
  );

  ratio_seq_ctl u_ctl (
    .clk(mclk),
    .rstN(rstN),
    .flags(flags),
    .cmd(cmd),
    .upQ(upQ)
  );

  assign poweredUp = upQ;
  assign dpReset   = ~upQ;
  assign ratio     = upQ ? ratioReg : '0;

endmodule

// File: tb/pwrup_ratio_seq_tb.sv
module pwrup_ratio_seq_tb;

  localparam int TO    = 64;
  localparam int CNT_W = $clog2(TO + 1);

  logic             mclk = 1'b0;
  logic             rstN = 1'b0;
  logic             lrck = 1'b0;
  logic [CNT_W-1:0] ratio;
  logic             dpReset;
  logic             poweredUp;

  int nChecks = 0;
  int nBad    = 0;

  always #5 mclk = ~mclk;

  pwrup_ratio_seq #(.TIMEOUT(TO)) u_dut (
    .mclk(mclk),
    .rstN(rstN),
    .lrck(lrck),
    .ratio(ratio),
    .dpReset(dpReset),
    .poweredUp(poweredUp)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge mclk);
  endtask

  // expected outputs from the requirements; R7 checked at every point
  task automatic chkOut(input string req, input int expUp, input int expRatio);
    chk(req, int'(poweredUp), expUp);
    chk(req, int'(ratio), expRatio);
    chk({req, "/R7"}, int'(dpReset), 1 - expUp);
  endtask

  task automatic doReset();
    lrck = 1'b0;
    rstN = 1'b0;
    waitNeg(3);
    rstN = 1'b1;
    waitNeg(1);
  endtask

  // one lrck period of p cycles, starting with a one-cycle high phase
  task automatic period(input int p);
    lrck = 1'b1;
    waitNeg(1);
    lrck = 1'b0;
    waitNeg(p - 1);
  endtask

  // a rise that is expected to change poweredUp three edges later
  task automatic riseAndCheck(input string req, input int upBefore, input int ratioBefore,
                              input int upAfter, input int ratioAfter);
    lrck = 1'b1;
    waitNeg(1);
    lrck = 1'b0;
    waitNeg(1);
    chkOut(req, upBefore, ratioBefore);
    waitNeg(1);
    chkOut(req, upAfter, ratioAfter);
  endtask

  initial begin
    doReset();
    chkOut("R1", 0, 0);

    // R2: no edges, lrck low and then high
    waitNeg(3 * TO);
    chkOut("R2", 0, 0);
    lrck = 1'b1;
    waitNeg(3 * TO);
    chkOut("R2", 0, 0);

    // R3/R4 sweep over every accepted ratio; p == TO is the edge/timeout collision (R5)
    for (int p = 2; p <= TO; p++) begin
      doReset();
      period(p);
      period(p);
      riseAndCheck((p == TO) ? "R5" : "R4", 0, 0, 1, p);
      waitNeg(1);
      chkOut("R3", 1, p);
    end

    // R5: period one longer than the limit never powers up
    doReset();
    for (int k = 0; k < 5; k++) period(TO + 1);
    chkOut("R5", 0, 0);

    // R5: clock loss while running, exact drop cycle
    doReset();
    period(20);
    period(20);
    lrck = 1'b1;
    waitNeg(1);
    lrck = 1'b0;
    waitNeg(2);
    chkOut("R4", 1, 20);
    waitNeg(TO - 1);
    chkOut("R5", 1, 20);
    waitNeg(1);
    chkOut("R5", 0, 0);
    // recovery after timeout
    period(16);
    period(16);
    riseAndCheck("R5", 0, 0, 1, 16);

    // R6: ratio step 20 -> 24 while running
    doReset();
    period(20);
    period(20);
    period(20);
    chkOut("R6", 1, 20);
    period(24);
    chkOut("R6", 1, 20);
    riseAndCheck("R6", 1, 20, 0, 0);
    waitNeg(21);
    period(24);
    riseAndCheck("R6", 0, 0, 1, 24);

    // R8: first count replaced by a differing second one
    doReset();
    period(10);
    period(12);
    riseAndCheck("R8", 0, 0, 0, 0);
    waitNeg(9);
    riseAndCheck("R8", 0, 0, 1, 12);

    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge mclk);
    nChecks++;
    nBad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule